// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order of column addresses for one read or write burst of a synchronous DRAM. A command pulse loads a start column together with a burst length code and an ordering select. From the next clock onward the block presents one column per cycle, along with a valid flag and a flag that marks the final beat.

Two orderings are offered. Sequential ordering counts upward and wraps inside the aligned block that the burst length defines. Interleave ordering XORs the beat number into the low column bits. There is also a page mode that counts through the entire 256-column row for as long as no terminate arrives.

A burst can be cut short at any cycle by a terminate input. It can also be replaced by a new command, which takes effect on the very next output beat. A command that asks for page mode with interleave ordering, or that uses an unassigned length code, is refused: the block flags it and it has no effect on the sequence.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, last_o and reject_o are all low.
- R2: With length code 0 (one beat), the cycle after an accepted command shows valid_o and last_o high together, and in the following cycle valid_o is low.
- R3: In sequential ordering with length code 1, 2 or 3 (2, 4 or 8 beats), beat n equals the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits stay those of the start column.
- R4: In interleave ordering with length code 1, 2 or 3, beat n equals the start column with its low log2(BL) bits XORed with n.
- R5: Length code 7 (page mode) with sequential ordering steps all 8 column bits by one per beat, modulo 256. last_o never rises, and the burst runs until a terminate or a new command arrives.
- R6: A command with length code 7 and interleave selected, or with code 4, 5 or 6, raises reject_o in the next cycle. It starts no burst, and any burst already running continues unchanged.
- R7: For fixed lengths, last_o is high exactly on beat BL-1. After that beat valid_o goes low unless a new command arrives.
- R8: term_i high in a cycle with no accepted command makes valid_o and last_o low from the next cycle, and no further beats follow.
- R9: An accepted command arriving during an active burst discards that burst. The next output is beat 0 of the new burst, which is its start column.
- R10: Every burst yields one column per clock, with valid_o held high over consecutive cycles from beat 0 to its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command pulse that begins a burst |
| start_col_i | input | 8 | Start column of the burst |
| len_code_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8 beats, 7=page; 4..6 unassigned |
| interleave_i | input | 1 | 1 selects interleave ordering, 0 sequential |
| term_i | input | 1 | Ends the running burst |
| col_o | output | 8 | Current column |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Current beat is the final one |
| reject_o | output | 1 | The previous cycle's command was refused |

## Verification
The assertions expect the inputs to be known in every cycle after reset, and they expect start_i to win over term_i whenever both are high. The step checks for page mode and for the upper column bits hold only in cycles where neither start_i nor term_i is high.

All stimulus is driven one cycle at a time, away from the clock edge. Commands, terminates and refused commands are placed on chosen beats: in the middle of bursts, on final beats and while the block is idle. This covers every transition the properties describe without ever leaving a control input undriven.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned COL_W_DEF = 8;
    localparam int unsigned LEN_W_DEF = 3;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = COL_W_DEF,
    parameter int unsigned LEN_W = LEN_W_DEF
) (
    input  logic [LEN_W-1:0] code_i,
    input  logic             il_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             illegal_o
);

    always_comb begin
        mask_o    = '0;
        page_o    = 1'b0;
        illegal_o = 1'b0;
        case (len_code_e'(code_i[2:0]))
            LEN_1:    mask_o = '0;
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o    = '1;
                page_o    = 1'b1;
                illegal_o = il_i;
            end
            default:  illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = COL_W_DEF
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             il_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = mask_i[i] ? (il_i ? (base_i[i] ^ beat_i[i]) : sum[i])
                                    : base_i[i];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = COL_W_DEF,
    parameter int unsigned LEN_W = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             interleave_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             reject_o
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             rej;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
        logic             il;
        logic             page;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_illegal;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] gen_col;
    logic             accept;

    burst_len_dec #(.COL_W(COL_W), .LEN_W(LEN_W)) i_dec (
        .code_i    (len_code_i),
        .il_i      (interleave_i),
        .mask_o    (dec_mask),
        .page_o    (dec_page),
        .illegal_o (dec_illegal)
    );

    assign beat_nx = st_q.beat + COL_W'(1);

    burst_col_gen #(.COL_W(COL_W)) i_gen (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .il_i   (st_q.il),
        .col_o  (gen_col)
    );

    assign accept = start_i && !dec_illegal;

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.col   = start_col_i;
            st_d.base  = start_col_i;
            st_d.mask  = dec_mask;
            st_d.beat  = '0;
            st_d.il    = interleave_i;
            st_d.page  = dec_page;
            st_d.last  = !dec_page && (dec_mask == '0);
        end else begin
            st_d.rej = start_i;
            if (term_i) begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
            end else if (st_q.valid && !st_q.last) begin
                st_d.beat = beat_nx;
                st_d.col  = gen_col;
                st_d.last = !st_q.page && (beat_nx == st_q.mask);
            end else begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o    = st_q.col;
    assign valid_o  = st_q.valid;
    assign last_o   = st_q.last;
    assign reject_o = st_q.rej;

    p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> (!valid_o && !last_o));

    p_reject_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec_illegal) |=> reject_o);

    p_reject_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec_illegal && !valid_o && !term_i) |=> !valid_o);

    p_start_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec_illegal) |=> (valid_o && col_o == $past(start_col_i)));

    p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !term_i) |=> valid_o);

    p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.page && !start_i && !term_i)
            |=> (valid_o && !last_o && col_o == COL_W'($past(col_o) + COL_W'(1))));

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !term_i)
            |=> (((col_o ^ $past(col_o)) & ~$past(st_q.mask)) == '0));

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, reject_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk, .rst_n, .start_i, .start_col_i, .len_code_i,
        .interleave_i, .term_i, .col_o, .valid_o, .last_o, .reject_o
    );

    typedef struct {
        bit         v;
        bit         l;
        bit         r;
        logic [7:0] c;
        string      tag;
    } exp_t;

    exp_t sb[$];

    function automatic int bl_of(logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 256;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(logic [7:0] b, int bl, bit il, int n);
        logic [7:0] m;
        m = 8'(bl - 1);
        if (il) return (b & ~m) | ((b ^ 8'(n)) & m);
        return (b & ~m) | ((b + 8'(n)) & m);
    endfunction

    task automatic cyc(bit st, logic [7:0] c, logic [2:0] code, bit il, bit tm,
                       bit ev, logic [7:0] ec, bit el, bit er, string tag);
        exp_t e;
        @(negedge clk);
        start_i = st; start_col_i = c; len_code_i = code;
        interleave_i = il; term_i = tm;
        e.v = ev; e.l = el; e.r = er; e.c = ec; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) cyc(0, 8'h00, 3'd0, 0, 0, 0, 8'h00, 0, 0, tag);
    endtask

    task automatic burst(logic [7:0] b, logic [2:0] code, bit il, int ncyc,
                         int term_at, string tag);
        int bl;
        bit page, v, l;
        bl   = bl_of(code);
        page = (code == 3'd7);
        for (int n = 0; n < ncyc; n++) begin
            v = (page || n < bl) && (term_at < 0 || n < term_at);
            l = v && !page && (n == bl - 1);
            cyc(n == 0, b, code, il, n == term_at, v, exp_col(b, bl, il, n), l, 0, tag);
        end
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (valid_o !== e.v || last_o !== e.l || reject_o !== e.r ||
                    (e.v && col_o !== e.c)) begin
                    errors++;
                    $display("FAIL %s: got v=%b col=%0d last=%b rej=%b, exp v=%b col=%0d last=%b rej=%b",
                             e.tag, valid_o, col_o, last_o, reject_o, e.v, e.c, e.l, e.r);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang, exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || last_o !== 1'b0 || reject_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%b l=%b r=%b, exp 0 0 0", valid_o, last_o, reject_o);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // R2 single beat
        burst(8'h35, 3'd0, 0, 3, -1, "R2");
        // R3 sequential wrap within aligned block
        burst(8'h2D, 3'd3, 0, 10, -1, "R3");
        burst(8'h0E, 3'd2, 0, 6, -1, "R3");
        burst(8'h13, 3'd1, 0, 4, -1, "R3");
        // R4 interleave ordering
        burst(8'h2D, 3'd3, 1, 10, -1, "R4");
        burst(8'h06, 3'd2, 1, 6, -1, "R4");
        burst(8'h11, 3'd1, 1, 3, -1, "R4");
        // R5 page mode wraps past 255 and ends only on terminate
        burst(8'hFA, 3'd7, 0, 263, 261, "R5");
        // R7 last on beat BL-1
        burst(8'h00, 3'd3, 0, 9, -1, "R7");
        // R8 terminate mid burst, then terminate while idle
        burst(8'h20, 3'd3, 0, 6, 3, "R8");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, 8'h00, 0, 0, "R8");
        // R9 restart mid burst, including from page mode
        burst(8'h40, 3'd3, 0, 3, -1, "R9");
        burst(8'h8B, 3'd2, 1, 6, -1, "R9");
        burst(8'h00, 3'd7, 0, 4, -1, "R9");
        burst(8'hC5, 3'd1, 0, 4, -1, "R9");
        // R6 refused commands while idle
        cyc(1, 8'h10, 3'd7, 1, 0, 0, 8'h00, 0, 1, "R6");
        cyc(1, 8'h10, 3'd5, 0, 0, 0, 8'h00, 0, 1, "R6");
        idle(1, "R6");
        // R6 refused command during a burst leaves it running
        burst(8'h50, 3'd3, 0, 3, -1, "R6");
        cyc(1, 8'h99, 3'd7, 1, 0, 1, exp_col(8'h50, 8, 0, 3), 0, 1, "R6");
        for (int n = 4; n < 8; n++)
            cyc(0, 8'h00, 3'd0, 0, 0, 1, exp_col(8'h50, 8, 0, n), n == 7, 0, "R6");
        idle(1, "R6");
        // R10 back-to-back bursts without gaps
        burst(8'h07, 3'd3, 1, 8, -1, "R10");
        burst(8'hF3, 3'd2, 0, 6, -1, "R10");
        idle(2, "R10");

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule